// File: doc/BRIEF.md
# Floppy Drive Control and Status Port

This block is a single byte-wide port that a processor uses to steer a floppy disk controller and the drives on its cable. Writing the port stores the drive selects, the recording density, the head side, a manual motor request and the enable for the data-request interrupt. Reading the same address returns live status in its upper three bits: the controller's data-request line, its command-complete interrupt line and a qualified drive-ready flag. The lower bits of a read come from an external sense-switch input. The read bits and the write bits share bit positions but are separate: nothing written can be read back.

The block also produces the two interrupt requests for the processor. The data-request interrupt is the higher-priority one and software can mask it. The command-complete interrupt is the lower-priority one and cannot be masked. The block drives the select, side, density and motor lines and a side indicator LED. It has two synchronous active-high resets: a hardware reset and a software reset. Both clear every stored control bit.

Top module: `floppy_csr`

## Requirements
- R1: A clock edge with `cs` and `wr` both high stores the write data as follows: bit 7 is the data-request interrupt enable, bit 4 is the manual motor request, bit 3 is the side, bit 2 is the density, bit 1 selects drive 1 and bit 0 selects drive 0. Bits 6 and 5 have no effect. `drv_sel`, `side_sel` and `dens_single` show the new values after that edge.
- R2: A clock edge with `cs` and `rd` both high loads `rdata` with {`fdc_drq`, `fdc_intrq`, not-ready, `sense_sw[4:0]`}, with not-ready in bit 5. At any other edge `rdata` is loaded with 0.
- R3: `rst` or `sw_rst` high at a clock edge clears every stored control bit to 0. After a hardware reset, `irq_hi`, `irq_lo`, `motor_on` and `rdata` are 0.
- R4: `irq_hi` is registered. It equals `fdc_drq` AND the stored enable, one cycle later. The DRQ bit of a read follows `fdc_drq` whatever the enable holds.
- R5: `irq_lo` is registered. It equals `fdc_intrq` one cycle later and has no enable.
- R6: `motor_on` is registered. It equals the manual motor bit OR `fdc_motor_on`, one cycle later.
- R7: `dens_single` follows the density bit: 0 selects double density and 1 selects single density.
- R8: `side_sel` follows the side bit. `led_side0` is its inverse, so the LED is lit for side 0.
- R9: Without the strap, the not-ready bit is 0 only when at least one drive is selected and every selected drive has its `drv_ready` bit high. When both selects are set, both `drv_sel` outputs are driven high.
- R10: With `no_ready_strap` high, the not-ready bit reads 0 regardless of selects and `drv_ready`.
- R11: A write strobe while `cs` is low leaves every stored control bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| cs | input | 1 | Port select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sense_sw | input | 5 | Sense-switch levels returned in read bits 4..0 |
| fdc_drq | input | 1 | Controller data request |
| fdc_intrq | input | 1 | Controller command-complete interrupt |
| fdc_motor_on | input | 1 | Controller motor-on output |
| drv_ready | input | 2 | Per-drive ready, 1 = ready |
| no_ready_strap | input | 1 | Strap for drives without a ready line |
| irq_hi | output | 1 | Maskable high-priority interrupt request |
| irq_lo | output | 1 | Unmaskable low-priority interrupt request |
| drv_sel | output | 2 | Drive select lines |
| side_sel | output | 1 | Head side select |
| dens_single | output | 1 | Density to controller, 1 = single |
| motor_on | output | 1 | Drive motor enable |
| led_side0 | output | 1 | Side indicator LED, 1 = lit |

## Verification
The bench uses the default parameters: an 8-bit port with two drives. At this size all 256 write codes can be applied, including the ignored bits 6 and 5. Every combination of select pattern, per-drive ready, strap, DRQ, INTRQ and interrupt enable is also reachable, so ready qualification and interrupt gating are checked against arithmetic expectations over their whole input space.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int N_DRV    = 2;
  localparam int BIT_EN   = 7;
  localparam int BIT_DRQ  = 7;
  localparam int BIT_INT  = 6;
  localparam int BIT_NRDY = 5;
  localparam int BIT_MOT  = 4;
  localparam int BIT_SIDE = 3;
  localparam int BIT_DENS = 2;

  typedef struct packed {
    logic             irq_en;
    logic             man_motor;
    logic             side;
    logic             dens;
    logic [N_DRV-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/fcsr_ctl_reg.sv
module fcsr_ctl_reg
  import fcsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl
);
  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.irq_en    <= wdata[BIT_EN];
      ctl.man_motor <= wdata[BIT_MOT];
      ctl.side      <= wdata[BIT_SIDE];
      ctl.dens      <= wdata[BIT_DENS];
      ctl.sel       <= wdata[N_DRV-1:0];
    end
  end

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (ctl == '0)) else $error("soft reset"); // R3
  AST_WR_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sw_rst) |=> (ctl.sel == $past(wdata[N_DRV-1:0]) &&
                            ctl.dens == $past(wdata[BIT_DENS]))) else $error("load"); // R1
  AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !sw_rst) |=> $stable(ctl)) else $error("hold"); // R11
endmodule

// File: rtl/fcsr_ready.sv
module fcsr_ready #(
  parameter int N_DRV = 2
) (
  input  logic [N_DRV-1:0] sel,
  input  logic [N_DRV-1:0] rdy,
  input  logic             strap,
  output logic             not_ready
);
  logic [N_DRV-1:0] miss;

  for (genvar i = 0; i < N_DRV; i++) begin : g_drv
    assign miss[i] = sel[i] & ~rdy[i];
  end

  always_comb begin
    if (strap) not_ready = 1'b0;
    else       not_ready = (~|sel) | (|miss);
  end
endmodule

// File: rtl/fcsr_outs.sv
module fcsr_outs #(
  parameter int DATA_W = 8,
  localparam int SW_W  = DATA_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              drq,
  input  logic              intrq,
  input  logic              not_ready,
  input  logic [SW_W-1:0]   sense,
  input  logic              drq_en,
  input  logic              man_motor,
  input  logic              fdc_mo,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              motor_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      irq_hi   <= 1'b0;
      irq_lo   <= 1'b0;
      motor_on <= 1'b0;
    end else begin
      rdata    <= rd_en ? {drq, intrq, not_ready, sense} : '0;
      irq_hi   <= drq & drq_en;
      irq_lo   <= intrq;
      motor_on <= man_motor | fdc_mo;
    end
  end

  AST_IRQ_HI_NEEDS_DRQ: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> ($past(drq) && $past(drq_en))) else $error("irq_hi"); // R4
  AST_IRQ_LO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_lo == $past(intrq))) else $error("irq_lo"); // R5
  AST_MOTOR_ON: assert property (@(posedge clk) disable iff (rst)
    (man_motor || fdc_mo) |=> motor_on) else $error("motor on"); // R6
  AST_MOTOR_OFF: assert property (@(posedge clk) disable iff (rst)
    (!man_motor && !fdc_mo) |=> !motor_on) else $error("motor off"); // R6
endmodule

// File: rtl/floppy_csr.sv
module floppy_csr
  import fcsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sw_rst,
  input  logic                   cs,
  input  logic                   rd,
  input  logic                   wr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  input  logic [DATA_W-4:0]      sense_sw,
  input  logic                   fdc_drq,
  input  logic                   fdc_intrq,
  input  logic                   fdc_motor_on,
  input  logic [N_DRV-1:0]       drv_ready,
  input  logic                   no_ready_strap,
  output logic                   irq_hi,
  output logic                   irq_lo,
  output logic [N_DRV-1:0]       drv_sel,
  output logic                   side_sel,
  output logic                   dens_single,
  output logic                   motor_on,
  output logic                   led_side0
);
  ctl_t ctl;
  logic not_ready;
  logic wr_en, rd_en;

  assign wr_en = cs & wr;
  assign rd_en = cs & rd;

  fcsr_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_en(wr_en),
    .wdata(wdata), .ctl(ctl)
  );

  fcsr_ready #(.N_DRV(N_DRV)) u_rdy (
    .sel(ctl.sel), .rdy(drv_ready), .strap(no_ready_strap),
    .not_ready(not_ready)
  );

  fcsr_outs #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd_en(rd_en), .drq(fdc_drq),
    .intrq(fdc_intrq), .not_ready(not_ready), .sense(sense_sw),
    .drq_en(ctl.irq_en), .man_motor(ctl.man_motor), .fdc_mo(fdc_motor_on),
    .rdata(rdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .motor_on(motor_on)
  );

  assign drv_sel     = ctl.sel;
  assign side_sel    = ctl.side;
  assign dens_single = ctl.dens;
  assign led_side0   = ~ctl.side;

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> (rdata == '0)) else $error("idle read"); // R2
  AST_READ_DRQ: assert property (@(posedge clk) disable iff (rst)
    (cs && rd) |=> (rdata[BIT_DRQ] == $past(fdc_drq) &&
                    rdata[BIT_INT] == $past(fdc_intrq))) else $error("read status"); // R2
  AST_STRAP_READY: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && no_ready_strap) |=> !rdata[BIT_NRDY]) else $error("strap"); // R10
  AST_NOSEL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !no_ready_strap && drv_sel == '0) |=> rdata[BIT_NRDY]) else $error("nosel"); // R9
  AST_LED_SIDE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (led_side0 != side_sel)) else $error("led"); // R8
endmodule

// File: tb/floppy_csr_test.sv
module floppy_csr_test;
  logic       clk = 0;
  logic       rst = 1, sw_rst = 0, cs = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [4:0] sense_sw = 0;
  logic       fdc_drq = 0, fdc_intrq = 0, fdc_motor_on = 0;
  logic [1:0] drv_ready = 0;
  logic       no_ready_strap = 0;
  logic       irq_hi, irq_lo, side_sel, dens_single, motor_on, led_side0;
  logic [1:0] drv_sel;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  floppy_csr uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cs(cs), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .sense_sw(sense_sw), .fdc_drq(fdc_drq),
    .fdc_intrq(fdc_intrq), .fdc_motor_on(fdc_motor_on), .drv_ready(drv_ready),
    .no_ready_strap(no_ready_strap), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .drv_sel(drv_sel), .side_sel(side_sel), .dens_single(dens_single),
    .motor_on(motor_on), .led_side0(led_side0)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] v, logic sel_cs);
    @(negedge clk); cs = sel_cs; wr = 1; wdata = v;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic do_read();
    @(negedge clk); cs = 1; rd = 1;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic chk_ctl(string req, logic [7:0] v);
    chk({req, " sel"},  {6'd0, drv_sel}, {6'd0, v[1:0]});
    chk({req, " dens"}, {7'd0, dens_single}, {7'd0, v[2]});
    chk({req, " side"}, {7'd0, side_sel}, {7'd0, v[3]});
    chk({req, " led"},  {7'd0, led_side0}, {7'd0, ~v[3]});
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: hardware reset state
    chk("R3 rdata", rdata, 8'h00);
    chk("R3 irq", {6'd0, irq_hi, irq_lo}, 8'h00);
    chk("R3 motor", {7'd0, motor_on}, 8'h00);
    chk_ctl("R3", 8'h00);
    rst = 0;

    // R1 R7 R8 R6 R4: sweep every write code; DRQ held high
    fdc_drq = 1;
    for (int v = 0; v < 256; v++) begin
      do_write(v[7:0], 1'b1);
      chk_ctl("R1", v[7:0]);
      @(negedge clk);
      chk("R6 manual motor", {7'd0, motor_on}, {7'd0, v[4]});
      chk("R4 gated irq", {7'd0, irq_hi}, {7'd0, v[7]});
      chk("R8 led", {7'd0, led_side0}, {7'd0, ~v[3]});
    end

    // R6: OR with controller motor-on
    for (int m = 0; m < 4; m++) begin
      do_write({3'd0, m[1], 4'd0}, 1'b1);
      fdc_motor_on = m[0];
      @(negedge clk);
      chk("R6 or", {7'd0, motor_on}, {7'd0, m[1] | m[0]});
    end
    fdc_motor_on = 0;

    // R9 R10 R2 R4 R5: status sweep
    for (int k = 0; k < 256; k++) begin
      logic [1:0] s, r;
      logic st, dq, iq, en, nr;
      s = k[1:0]; r = k[3:2]; st = k[4]; dq = k[5]; iq = k[6]; en = k[7];
      do_write({en, 5'd0, s}, 1'b1);
      drv_ready = r; no_ready_strap = st; fdc_drq = dq; fdc_intrq = iq;
      sense_sw = k[4:0] ^ 5'h15;
      do_read();
      nr = st ? 1'b0 : ((s == 2'b00) || ((s & ~r) != 2'b00));
      chk(st ? "R10 read" : "R9 read", rdata, {dq, iq, nr, k[4:0] ^ 5'h15});
      chk("R4 irq_hi", {7'd0, irq_hi}, {7'd0, dq & en});
      chk("R5 irq_lo", {7'd0, irq_lo}, {7'd0, iq});
      chk("R9 both sel", {6'd0, drv_sel}, {6'd0, s});
    end

    // R2: read strobe without cs returns 0
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    chk("R2 no cs", rdata, 8'h00);

    // R11: write without cs ignored
    do_write(8'h00, 1'b1);
    do_write(8'hFF, 1'b0);
    @(negedge clk);
    chk_ctl("R11", 8'h00);
    chk("R11 motor", {7'd0, motor_on}, 8'h00);

    // R3: software reset clears control bits
    fdc_drq = 1;
    do_write(8'hFF, 1'b1);
    @(negedge clk); sw_rst = 1;
    @(negedge clk); sw_rst = 0;
    chk_ctl("R3 soft", 8'h00);
    @(negedge clk);
    chk("R3 soft irq", {7'd0, irq_hi}, 8'h00);
    chk("R3 soft motor", {7'd0, motor_on}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule